// File: doc/BRIEF.md
# DRAM Command Scheduler with Posted Column Commands

This block sequences accesses for a DRAM with several internal banks onto one shared command bus made of active-low RAS, CAS and WE lines. Each request names a bank and a direction (read or write). The block turns each request into a bank activate followed by a column command. It never drives more than one command in a clock.

The block has two modes, chosen at build time by `ADD_LAT`. With `ADD_LAT` = 0 it runs in conventional mode. The column command goes out `T_RCD` cycles after its activate, and activates are spaced by `T_RRD`. If a new activate would land on a cycle already taken by a column command, the column command keeps that cycle and the activate moves back one clock, together with everything that follows from it. With `ADD_LAT` > 0 it runs in posted mode. The column command goes out on the clock right after its own activate, and the device holds it internally for `ADD_LAT` cycles. A saturated stream then alternates activate and column cycles, so the two kinds of command never collide.

A strobe output marks the cycle in which each column command takes effect inside the device. That is the point from which data is expected. The strobe carries the bank and the direction.

Top module: `dram_cmd_sched`

## Requirements
- R1: Every cycle the bus carries exactly one code on {ras_n_o, cas_n_o, we_n_o}: activate 011, read 101, write 100, no-operation 111. No-operation is driven whenever nothing is scheduled.
- R2: After reset the bus shows no-operation 111, req_ready_o is high and col_stb_o is low.
- R3: Two activates on the bus are never closer than `T_RRD` cycles (default 2). While the next bus cycle would break that spacing, req_ready_o is low.
- R4: In conventional mode the column command for an access appears exactly `T_RCD` cycles (default 4) after its activate. It carries the same bank on cmd_bank_o and is read (101) or write (100) according to the request.
- R5: When an activate and an already scheduled column command would fall on the same bus cycle, the column command is driven and the activate waits one clock. req_ready_o is low for that cycle.
- R6: When an activate is deferred, its own column command follows the deferred activate by `T_RCD`, so it moves back by the same amount.
- R7: In posted mode every activate is followed on the next clock by its column command. A back-to-back request stream puts activates and column commands on alternating cycles.
- R8: col_stb_o pulses once per column command, with col_bank_o and col_write_o set to that command's bank and direction. In conventional mode the pulse is in the same cycle as the column command on the bus. In posted mode it comes `ADD_LAT` cycles later.
- R9: A request is accepted on a rising edge where req_valid_i and req_ready_o are both high. Its activate is on the bus in the next cycle, with the request's bank on cmd_bank_o.
- R10: `ADD_LAT` = 0 selects conventional placement based on `T_RCD`; any value above zero selects posted placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | An activate can be placed on the next bus cycle |
| req_bank_i | input | $clog2(NUM_BANKS) | Target bank of the request |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| ras_n_o | output | 1 | Row strobe line, active low |
| cas_n_o | output | 1 | Column strobe line, active low |
| we_n_o | output | 1 | Write enable line, active low |
| cmd_bank_o | output | $clog2(NUM_BANKS) | Bank of the command on the bus (0 on no-operation) |
| col_stb_o | output | 1 | Column command takes effect in the device this cycle |
| col_bank_o | output | $clog2(NUM_BANKS) | Bank of the effective column command |
| col_write_o | output | 1 | Direction of the effective column command |

## Verification
The conventional run saturates the request port with four accesses so that the third activate lands on the first column slot. A design that let the activate win, or that dropped the collision check, would put two commands into one cycle or move a column command away from its `T_RCD` offset. A design that deferred the activate but not its column command would issue a read before its row was open. The posted run sends the same stream. Any extra gap between activate and column command, or a strobe that does not trail its column command by `ADD_LAT`, shows up as a shifted or missing entry in the cycle log. That run also shows strobes evenly spaced two cycles apart, while the conventional run shows the bubble. The spacing of ready against `T_RRD` and the pairing of bank and direction on each strobe are compared cycle by cycle.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  // {ras_n, cas_n, we_n}, active low
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010,
    CMD_REF = 3'b001,
    CMD_NOP = 3'b111
  } bus_cmd_e;
endpackage

// File: rtl/col_slot_pipe.sv
// Column command schedule: an entry loaded now is due on the bus DEPTH+1 cycles later.
module col_slot_pipe #(
  parameter int DEPTH = 4,
  parameter int BW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] load_bank_i,
  input  logic          load_wr_i,
  output logic          due_o,
  output logic [BW-1:0] due_bank_o,
  output logic          due_wr_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] wr_q;
  logic [BW-1:0]    bank_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k]  <= 1'b0;
          wr_q[k]   <= 1'b0;
          bank_q[k] <= '0;
        end else begin
          vld_q[k]  <= load_i;
          wr_q[k]   <= load_wr_i;
          bank_q[k] <= load_bank_i;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k]  <= 1'b0;
          wr_q[k]   <= 1'b0;
          bank_q[k] <= '0;
        end else begin
          vld_q[k]  <= vld_q[k+1];
          wr_q[k]   <= wr_q[k+1];
          bank_q[k] <= bank_q[k+1];
        end
      end
    end
  end

  assign due_o      = vld_q[0];
  assign due_wr_o   = wr_q[0];
  assign due_bank_o = bank_q[0];
endmodule

// File: rtl/act_spacer.sv
// Tracks distance from the last activate to the bus cycle being decided.
module act_spacer #(
  parameter int T_RRD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic ok_o
);
  localparam int CW = $clog2(T_RRD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(T_RRD);

  logic [CW-1:0] dist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             dist_q <= LIMIT;
    else if (act_i)          dist_q <= CW'(1);
    else if (dist_q < LIMIT) dist_q <= dist_q + CW'(1);
  end

  assign ok_o = dist_q >= LIMIT;
endmodule

// File: rtl/col_stb_delay.sv
// Delays the column-effective strobe by LAT cycles (pass-through at 0).
module col_stb_delay #(
  parameter int LAT = 0,
  parameter int BW  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [BW-1:0] bank_i,
  input  logic          wr_i,
  output logic          stb_o,
  output logic [BW-1:0] bank_o,
  output logic          wr_o
);
  if (LAT == 0) begin : g_thru
    assign stb_o  = stb_i;
    assign bank_o = bank_i;
    assign wr_o   = wr_i;
  end else begin : g_chain
    logic [LAT-1:0] stb_q;
    logic [LAT-1:0] wr_q;
    logic [BW-1:0]  bank_q [LAT];
    for (genvar k = 0; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stb_q[k]  <= 1'b0;
          wr_q[k]   <= 1'b0;
          bank_q[k] <= '0;
        end else if (k == 0) begin
          stb_q[k]  <= stb_i;
          wr_q[k]   <= wr_i;
          bank_q[k] <= bank_i;
        end else begin
          stb_q[k]  <= stb_q[k-1];
          wr_q[k]   <= wr_q[k-1];
          bank_q[k] <= bank_q[k-1];
        end
      end
    end
    assign stb_o  = stb_q[LAT-1];
    assign bank_o = bank_q[LAT-1];
    assign wr_o   = wr_q[LAT-1];
  end
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
  import dram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RRD     = 2,
  parameter int T_RCD     = 4,
  parameter int ADD_LAT   = 0,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [BW-1:0] req_bank_i,
  input  logic          req_write_i,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          we_n_o,
  output logic [BW-1:0] cmd_bank_o,
  output logic          col_stb_o,
  output logic [BW-1:0] col_bank_o,
  output logic          col_write_o
);
  localparam bit POSTED  = ADD_LAT > 0;
  localparam int COL_DLY = POSTED ? 1 : T_RCD;

  logic          col_due, col_due_wr;
  logic [BW-1:0] col_due_bank;
  logic          rrd_ok, act_go;

  bus_cmd_e      cmd_d, cmd_q;
  logic [BW-1:0] bank_d, bank_q;
  logic          colv_q, colw_q;
  logic [BW-1:0] colb_q;

  // Column command holds its slot; activate waits for a free, spaced slot.
  assign req_ready_o = !col_due && rrd_ok;
  assign act_go      = req_valid_i && req_ready_o;

  col_slot_pipe #(.DEPTH(COL_DLY), .BW(BW)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (act_go),
    .load_bank_i (req_bank_i),
    .load_wr_i   (req_write_i),
    .due_o       (col_due),
    .due_bank_o  (col_due_bank),
    .due_wr_o    (col_due_wr)
  );

  act_spacer #(.T_RRD(T_RRD)) u_rrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_go),
    .ok_o   (rrd_ok)
  );

  always_comb begin
    cmd_d  = CMD_NOP;
    bank_d = '0;
    if (col_due) begin
      cmd_d  = col_due_wr ? CMD_WR : CMD_RD;
      bank_d = col_due_bank;
    end else if (act_go) begin
      cmd_d  = CMD_ACT;
      bank_d = req_bank_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      colv_q <= 1'b0;
      colw_q <= 1'b0;
      colb_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      colv_q <= col_due;
      colw_q <= col_due_wr;
      colb_q <= col_due_bank;
    end
  end

  assign {ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cmd_bank_o = bank_q;

  col_stb_delay #(.LAT(ADD_LAT), .BW(BW)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (colv_q),
    .bank_i (colb_q),
    .wr_i   (colw_q),
    .stb_o  (col_stb_o),
    .bank_o (col_bank_o),
    .wr_o   (col_write_o)
  );
endmodule

// File: rtl/dram_cmd_sched_chk.sv
module dram_cmd_sched_chk
  import dram_cmd_pkg::*;
#(
  parameter int BW      = 2,
  parameter int T_RRD   = 2,
  parameter int ADD_LAT = 0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [BW-1:0] req_bank_i,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          we_n_o,
  input logic [BW-1:0] cmd_bank_o,
  input logic          col_stb_o
);
  localparam int CW = $clog2(T_RRD + 1);

  logic [2:0] bus;
  logic       is_act, is_col;
  logic [CW-1:0] since_act_q;

  assign bus    = {ras_n_o, cas_n_o, we_n_o};
  assign is_act = bus == CMD_ACT;
  assign is_col = (bus == CMD_RD) || (bus == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_act_q <= CW'(T_RRD);
    else if (is_act)                      since_act_q <= CW'(1);
    else if (since_act_q < CW'(T_RRD))    since_act_q <= since_act_q + CW'(1);
  end

  AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act || is_col || bus == CMD_NOP); // R1

  AST_RRD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_act_q >= CW'(T_RRD)); // R3

  AST_ACCEPT_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (is_act && cmd_bank_o == $past(req_bank_i))); // R9

  if (ADD_LAT > 0) begin : g_posted
    AST_POSTED_BUNDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_act |=> (is_col && $stable(cmd_bank_o))); // R7
  end else begin : g_conv
    AST_STB_WITH_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_stb_o == is_col); // R8
  end
endmodule

bind dram_cmd_sched dram_cmd_sched_chk #(
  .BW      (BW),
  .T_RRD   (T_RRD),
  .ADD_LAT (ADD_LAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_bank_i  (req_bank_i),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .cmd_bank_o  (cmd_bank_o),
  .col_stb_o   (col_stb_o)
);

// File: tb/dram_cmd_sched_test.sv
`timescale 1ns/1ps
module dram_cmd_sched_test;
  localparam int NSTEP = 24;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic       vc = 1'b0, vp = 1'b0;
  logic [1:0] bank = '0;
  logic       wr = 1'b0;

  logic       rdy_c, ras_c, cas_c, we_c, stb_c, sw_c;
  logic [1:0] cb_c, sb_c;
  logic       rdy_p, ras_p, cas_p, we_p, stb_p, sw_p;
  logic [1:0] cb_p, sb_p;

  dram_cmd_sched #(.NUM_BANKS(4), .T_RRD(2), .T_RCD(4), .ADD_LAT(0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(vc), .req_ready_o(rdy_c),
    .req_bank_i(bank), .req_write_i(wr), .ras_n_o(ras_c), .cas_n_o(cas_c),
    .we_n_o(we_c), .cmd_bank_o(cb_c), .col_stb_o(stb_c), .col_bank_o(sb_c),
    .col_write_o(sw_c));

  dram_cmd_sched #(.NUM_BANKS(4), .T_RRD(2), .T_RCD(4), .ADD_LAT(3)) uut_post (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(vp), .req_ready_o(rdy_p),
    .req_bank_i(bank), .req_write_i(wr), .ras_n_o(ras_p), .cas_n_o(cas_p),
    .we_n_o(we_p), .cmd_bank_o(cb_p), .col_stb_o(stb_p), .col_bank_o(sb_p),
    .col_write_o(sw_p));

  int n_chk = 0, n_bad = 0;

  logic [1:0] q_bank [8];
  logic       q_wr   [8];
  logic [2:0] e_cmd [NSTEP];
  logic [1:0] e_bank[NSTEP];
  logic       e_stb [NSTEP];
  logic [1:0] e_sb  [NSTEP];
  logic       e_sw  [NSTEP];
  logic [2:0] g_cmd [NSTEP];
  logic [1:0] g_bank[NSTEP];
  logic       g_stb [NSTEP];
  logic [1:0] g_sb  [NSTEP];
  logic       g_sw  [NSTEP];
  logic       g_rdy [NSTEP];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < NSTEP; i++) begin
      e_cmd[i] = C_NOP; e_bank[i] = '0; e_stb[i] = 1'b0; e_sb[i] = '0; e_sw[i] = 1'b0;
    end
  endtask

  task automatic put_cmd(input int s, input logic [2:0] c, input logic [1:0] b);
    e_cmd[s] = c; e_bank[s] = b;
  endtask

  task automatic put_stb(input int s, input logic [1:0] b, input logic w);
    e_stb[s] = 1'b1; e_sb[s] = b; e_sw[s] = w;
  endtask

  task automatic do_reset();
    vc = 1'b0; vp = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // Step s sample reflects the bus cycle after edge s-1; a handshake at step s shows at s+1.
  task automatic run(input bit posted, input int nreq);
    int idx = 0;
    for (int s = 0; s < NSTEP; s++) begin
      if (posted) begin
        g_cmd[s] = {ras_p, cas_p, we_p}; g_bank[s] = cb_p; g_stb[s] = stb_p;
        g_sb[s] = sb_p; g_sw[s] = sw_p; g_rdy[s] = rdy_p;
      end else begin
        g_cmd[s] = {ras_c, cas_c, we_c}; g_bank[s] = cb_c; g_stb[s] = stb_c;
        g_sb[s] = sb_c; g_sw[s] = sw_c; g_rdy[s] = rdy_c;
      end
      if (idx < nreq) begin
        bank = q_bank[idx]; wr = q_wr[idx];
        vc = !posted; vp = posted;
        if (g_rdy[s]) idx++;
      end else begin
        vc = 1'b0; vp = 1'b0;
      end
      @(negedge clk);
    end
    vc = 1'b0; vp = 1'b0;
  endtask

  task automatic compare(input string rq);
    for (int s = 0; s < NSTEP; s++) begin
      chk(g_cmd[s] == e_cmd[s], {rq, " bus code"}, int'(g_cmd[s]), int'(e_cmd[s]));
      if (e_cmd[s] != C_NOP)
        chk(g_bank[s] == e_bank[s], {rq, " cmd bank"}, int'(g_bank[s]), int'(e_bank[s]));
      chk(g_stb[s] == e_stb[s], "R8 strobe", int'(g_stb[s]), int'(e_stb[s]));
      if (e_stb[s]) begin
        chk(g_sb[s] == e_sb[s], "R8 strobe bank", int'(g_sb[s]), int'(e_sb[s]));
        chk(g_sw[s] == e_sw[s], "R8 strobe dir", int'(g_sw[s]), int'(e_sw[s]));
      end
    end
  endtask

  task automatic test_reset();
    do_reset();
    chk({ras_c, cas_c, we_c} == C_NOP, "R2 conv bus", int'({ras_c, cas_c, we_c}), int'(C_NOP));
    chk({ras_p, cas_p, we_p} == C_NOP, "R2 posted bus", int'({ras_p, cas_p, we_p}), int'(C_NOP));
    chk(rdy_c && rdy_p, "R2 ready", int'(rdy_c & rdy_p), 1);
    chk(!stb_c && !stb_p, "R2 strobe", int'(stb_c | stb_p), 0);
  endtask

  task automatic load_stream();
    q_bank[0] = 2'd0; q_wr[0] = 1'b0;
    q_bank[1] = 2'd1; q_wr[1] = 1'b1;
    q_bank[2] = 2'd2; q_wr[2] = 1'b0;
    q_bank[3] = 2'd3; q_wr[3] = 1'b1;
  endtask

  // R4 R5 R6 R9: third activate meets first column slot and is deferred
  task automatic test_conv_stream();
    do_reset();
    load_stream();
    clear_exp();
    put_cmd(1, C_ACT, 2'd0);  put_cmd(3, C_ACT, 2'd1);
    put_cmd(5, C_RD, 2'd0);   put_cmd(6, C_ACT, 2'd2);
    put_cmd(7, C_WR, 2'd1);   put_cmd(8, C_ACT, 2'd3);
    put_cmd(10, C_RD, 2'd2);  put_cmd(12, C_WR, 2'd3);
    put_stb(5, 2'd0, 1'b0);   put_stb(7, 2'd1, 1'b1);
    put_stb(10, 2'd2, 1'b0);  put_stb(12, 2'd3, 1'b1);
    run(1'b0, 4);
    compare("R1/R4/R5/R6/R9 conv");
    chk(g_rdy[1] == 1'b0, "R3 ready low inside tRRD", int'(g_rdy[1]), 0);
    chk(g_rdy[2] == 1'b1, "R3 ready high at tRRD", int'(g_rdy[2]), 1);
    chk(g_rdy[4] == 1'b0, "R5 ready low on collision", int'(g_rdy[4]), 0);
  endtask

  // R7 R10: same stream, posted mode alternates activate and column
  task automatic test_posted_stream();
    do_reset();
    load_stream();
    clear_exp();
    for (int i = 0; i < 4; i++) begin
      put_cmd(1 + 2 * i, C_ACT, 2'(i));
      put_cmd(2 + 2 * i, q_wr[i] ? C_WR : C_RD, 2'(i));
      put_stb(5 + 2 * i, 2'(i), q_wr[i]);
    end
    run(1'b1, 4);
    compare("R1/R7/R10 posted");
    chk(g_rdy[1] == 1'b0, "R7 ready low on bundled column", int'(g_rdy[1]), 0);
  endtask

  // R4: isolated write, exact tRCD offset; idle cycles stay NOP (R1)
  task automatic test_single_write();
    do_reset();
    q_bank[0] = 2'd2; q_wr[0] = 1'b1;
    clear_exp();
    put_cmd(1, C_ACT, 2'd2);
    put_cmd(5, C_WR, 2'd2);
    put_stb(5, 2'd2, 1'b1);
    run(1'b0, 1);
    compare("R1/R4 single");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_conv_stream();
    test_posted_stream();
    test_single_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule